// File: doc/BRIEF.md
# Compact Instruction Decode-Execute Unit

This block sits behind an instruction fetch unit. It decodes a mixed-length instruction stream and executes its two-byte compact subset. The fetch unit presents a 24-bit window with a valid strobe. The block answers at once with the length of the instruction at the window's low byte, so the fetch unit knows whether to step the program counter by two or by three bytes.

Compact instructions read and write a private file of sixteen 32-bit registers. The block executes register adds, adds with a small immediate, register moves, move-immediates, word loads, word stores, a no-op and a return. Loads and stores leave the block as one-cycle requests on a plain memory request/response interface. A load holds the unit busy until its response arrives.

Every accepted instruction finishes with exactly one completion pulse, on one of four outputs:
- `pc_adv_o` for a normal finish,
- `jump_valid_o` for a return, with `jump_target_o` set,
- `unsupported_o` for a recognised encoding that this unit does not execute,
- `illegal_o` for a reserved encoding.

Top module: `cmp_exec_unit`

## Requirements
- R1: The low nibble `fetch_word_i[3:0]` is the primary opcode. `inst_len_o` is 2 when that nibble is 8 or greater and 3 otherwise. This output is combinational and always valid. In compact words the fields are t=[7:4], s=[11:8] and r=[15:12].
- R2: Opcode 8 (load) places a request one cycle after acceptance, with `mem_req_we_o`=0 and address R[s]+4*r. `busy_o` then stays high until a cycle with `mem_rsp_valid_i`=1. At that edge R[t] takes `mem_rsp_data_i`, and `pc_adv_o` pulses in the following cycle.
- R3: Opcode 9 (store) places a request one cycle after acceptance, with `mem_req_we_o`=1, address R[s]+4*r and write data R[t]. `pc_adv_o` pulses in the same cycle.
- R4: Opcode 10 writes R[s]+R[t] into R[r].
- R5: Opcode 11 writes R[s]+t into R[r]. When t is 0, the addend is -1 instead.
- R6: Opcode 12 with t<8 writes a 7-bit value {t[2:0], r} into R[s]. Bits 31..7 are filled with ones when t[2:1]=11 and with zeros otherwise. The range of values is -32 to 95.
- R7: Opcode 13 with r=0 copies R[s] into R[t].
- R8: Opcode 13 with r=15 and t=0 is a return. One cycle after acceptance, `jump_valid_o` pulses with `jump_target_o` equal to R[0], and `pc_adv_o` stays low.
- R9: Opcode 13 with r=15 and t=3 is a no-op. It only pulses `pc_adv_o`.
- R10: The following encodings pulse `unsupported_o` and change no register or memory:
  - opcodes 0 to 7,
  - opcode 12 with t>=8,
  - opcode 13 with r=15 and t of 1 or 2.
- R11: The following encodings pulse `illegal_o` and change no register or memory:
  - opcode 13 with r=15 and t of 6 or any other value not listed in R8, R9 or R10,
  - opcode 13 with r outside {0,15},
  - opcodes 14 and 15.
- R12: While `busy_o` is high, `fetch_valid_i` is ignored. A memory response that arrives while not busy is ignored.
- R13: After synchronous reset, every output pulse and `busy_o` are low and all sixteen registers hold 0.
- R14: Each accepted instruction produces exactly one of `pc_adv_o`, `jump_valid_o`, `illegal_o` or `unsupported_o`, and never two of them in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid_i | input | 1 | Fetch window holds an instruction to execute |
| fetch_word_i | input | 24 | Fetch window, low byte first |
| inst_len_o | output | 2 | Instruction length in bytes (2 or 3) |
| busy_o | output | 1 | Load outstanding; new instructions are not taken |
| mem_req_valid_o | output | 1 | One-cycle memory request |
| mem_req_we_o | output | 1 | Request is a store |
| mem_req_addr_o | output | XLEN | Word address of the request |
| mem_req_wdata_o | output | XLEN | Store data |
| mem_rsp_valid_i | input | 1 | Load response valid |
| mem_rsp_data_i | input | XLEN | Load response data |
| pc_adv_o | output | 1 | Instruction completed; advance PC by 2 |
| jump_valid_o | output | 1 | Return taken |
| jump_target_o | output | XLEN | Return target address |
| illegal_o | output | 1 | Reserved encoding seen |
| unsupported_o | output | 1 | Recognised but unexecuted encoding seen |

## Verification
The bench builds the unit with its default 32-bit data width. At that width the extremes of the move-immediate sign extension (-32, 95 and -1) show as full words, and an add-immediate of -1 can be told apart from a wrap. Registers are observed only through stores to a known base, so every write, and every case where a write was suppressed, reaches the memory request port. Loads are held open for several cycles while a competing instruction is offered and a stray response is sent, which exercises the busy interlock at both of its ends.

// File: rtl/cmp_exec_pkg.sv
// Shared definitions for the compact decode-execute unit.
// Assumes the compact register fields are four bits wide.
package cmp_exec_pkg;
    localparam int FIELD_W = 4;

    typedef enum logic [3:0] {
        OPK_LOAD, OPK_STORE, OPK_ADD, OPK_ADDI, OPK_MOVI,
        OPK_MOV, OPK_RET, OPK_NOP, OPK_UNSUP, OPK_ILL
    } op_kind_e;

    typedef struct packed {
        op_kind_e           kind;
        logic [FIELD_W-1:0] rd;
        logic [FIELD_W-1:0] ra;
        logic [FIELD_W-1:0] rb;
        logic               use_rb;
        logic               wr;
    } dec_t;
endpackage

// File: rtl/cmp_decoder.sv
// Length decode and compact-instruction field decode.
// Purely combinational. Assumes the opcode sits in word[3:0] and that,
// in compact words, t, s and r are the next three nibbles in that order.
module cmp_decoder
    import cmp_exec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [23:0]     word_i,
    output logic [1:0]      len_o,
    output dec_t            dec_o,
    output logic [XLEN-1:0] imm_o
);
    logic [3:0] op, ft, fs, fr;
    assign op = word_i[3:0];
    assign ft = word_i[7:4];
    assign fs = word_i[11:8];
    assign fr = word_i[15:12];

    // Length: the top bit of the opcode nibble selects the compact form
    assign len_o = op[3] ? 2'd2 : 2'd3;

    // Field decode: select the operation kind, operands and immediate
    always_comb begin
        dec_o = '{kind: OPK_ILL, rd: '0, ra: '0, rb: '0, use_rb: 1'b0, wr: 1'b0};
        imm_o = '0;
        if (!op[3]) begin
            dec_o.kind = OPK_UNSUP;
        end else begin
            case (op)
                4'd8: begin
                    dec_o.kind = OPK_LOAD;
                    dec_o.rd   = ft;
                    dec_o.ra   = fs;
                    imm_o      = {{(XLEN-6){1'b0}}, fr, 2'b00};
                end
                4'd9: begin
                    dec_o.kind = OPK_STORE;
                    dec_o.ra   = fs;
                    dec_o.rb   = ft;
                    imm_o      = {{(XLEN-6){1'b0}}, fr, 2'b00};
                end
                4'd10: begin
                    dec_o.kind   = OPK_ADD;
                    dec_o.rd     = fr;
                    dec_o.ra     = fs;
                    dec_o.rb     = ft;
                    dec_o.use_rb = 1'b1;
                    dec_o.wr     = 1'b1;
                end
                4'd11: begin
                    dec_o.kind = OPK_ADDI;
                    dec_o.rd   = fr;
                    dec_o.ra   = fs;
                    dec_o.wr   = 1'b1;
                    imm_o      = (ft == 4'd0) ? {XLEN{1'b1}} : {{(XLEN-4){1'b0}}, ft};
                end
                4'd12: begin
                    if (!ft[3]) begin
                        dec_o.kind = OPK_MOVI;
                        dec_o.rd   = fs;
                        dec_o.wr   = 1'b1;
                        imm_o      = {{(XLEN-7){ft[2] & ft[1]}}, ft[2:0], fr};
                    end else begin
                        dec_o.kind = OPK_UNSUP;
                    end
                end
                4'd13: begin
                    if (fr == 4'd0) begin
                        dec_o.kind = OPK_MOV;
                        dec_o.rd   = ft;
                        dec_o.ra   = fs;
                        dec_o.wr   = 1'b1;
                    end else if (fr == 4'd15) begin
                        case (ft)
                            4'd0:       dec_o.kind = OPK_RET;
                            4'd3:       dec_o.kind = OPK_NOP;
                            4'd1, 4'd2: dec_o.kind = OPK_UNSUP;
                            default:    dec_o.kind = OPK_ILL;
                        endcase
                    end
                end
                default: dec_o.kind = OPK_ILL;
            endcase
        end
    end

    // Guard on the move-immediate range
    always_comb begin
        if (dec_o.kind == OPK_MOVI) begin
            // R6
            movi_range_chk: assert ($signed(imm_o) >= -32 && $signed(imm_o) <= 95);
        end
    end
endmodule

// File: rtl/cmp_regfile.sv
// Register file with two combinational read ports and one write port.
// Assumes at most one write per cycle; cleared by synchronous reset.
module cmp_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_i,
    input  logic [$clog2(NREG)-1:0] widx_i,
    input  logic [XLEN-1:0]         wdata_i,
    input  logic [$clog2(NREG)-1:0] ra_idx_i,
    input  logic [$clog2(NREG)-1:0] rb_idx_i,
    output logic [XLEN-1:0]         ra_o,
    output logic [XLEN-1:0]         rb_o
);
    localparam int IDX_W = $clog2(NREG);

    logic [XLEN-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Entry g: clear on reset, load on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we_i && widx_i == IDX_W'(g))
                regs[g] <= wdata_i;
        end
    end

    assign ra_o = regs[ra_idx_i];
    assign rb_o = regs[rb_idx_i];
endmodule

// File: rtl/cmp_lsu.sv
// Load/store issue: sends one-cycle memory requests, tracks the single
// outstanding load and presents its write-back. Assumes the caller does
// not start a new access while busy_o is high.
module cmp_lsu #(
    parameter int XLEN  = 32,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_go_i,
    input  logic             st_go_i,
    input  logic [XLEN-1:0]  addr_i,
    input  logic [XLEN-1:0]  wdata_i,
    input  logic [IDX_W-1:0] ld_rd_i,
    input  logic             rsp_valid_i,
    input  logic [XLEN-1:0]  rsp_data_i,
    output logic             req_valid_o,
    output logic             req_we_o,
    output logic [XLEN-1:0]  req_addr_o,
    output logic [XLEN-1:0]  req_wdata_o,
    output logic             busy_o,
    output logic             wb_valid_o,
    output logic [IDX_W-1:0] wb_idx_o,
    output logic [XLEN-1:0]  wb_data_o
);
    logic [IDX_W-1:0] pend_rd;

    // Request register: one-cycle pulse with its address and data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid_o <= 1'b0;
            req_we_o    <= 1'b0;
            req_addr_o  <= '0;
            req_wdata_o <= '0;
        end else begin
            req_valid_o <= ld_go_i | st_go_i;
            if (ld_go_i | st_go_i) begin
                req_we_o    <= st_go_i;
                req_addr_o  <= addr_i;
                req_wdata_o <= st_go_i ? wdata_i : '0;
            end
        end
    end

    // Outstanding-load tracker: set on issue, cleared by the response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o  <= 1'b0;
            pend_rd <= '0;
        end else if (ld_go_i) begin
            busy_o  <= 1'b1;
            pend_rd <= ld_rd_i;
        end else if (busy_o && rsp_valid_i) begin
            busy_o <= 1'b0;
        end
    end

    assign wb_valid_o = busy_o & rsp_valid_i;
    assign wb_idx_o   = pend_rd;
    assign wb_data_o  = rsp_data_i;

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !rsp_valid_i) |=> busy_o);
    // R2
    load_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (req_valid_o && !req_we_o));
endmodule

// File: rtl/cmp_exec_unit.sv
// Top of the compact decode-execute unit. It accepts an instruction when
// fetch_valid_i is high and no load is pending, executes it through the
// register file and the load/store issue logic, and reports completion
// one cycle later (a load completes one cycle after its response).
module cmp_exec_unit
    import cmp_exec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_valid_i,
    input  logic [23:0]     fetch_word_i,
    output logic [1:0]      inst_len_o,
    output logic            busy_o,
    output logic            mem_req_valid_o,
    output logic            mem_req_we_o,
    output logic [XLEN-1:0] mem_req_addr_o,
    output logic [XLEN-1:0] mem_req_wdata_o,
    input  logic            mem_rsp_valid_i,
    input  logic [XLEN-1:0] mem_rsp_data_i,
    output logic            pc_adv_o,
    output logic            jump_valid_o,
    output logic [XLEN-1:0] jump_target_o,
    output logic            illegal_o,
    output logic            unsupported_o
);
    localparam int NREG  = 1 << FIELD_W;
    localparam int IDX_W = FIELD_W;

    dec_t            dec;
    logic [XLEN-1:0] imm, ra_val, rb_val, opb, sum, alu_res, rf_wdata;
    logic [IDX_W-1:0] rf_widx, wb_idx;
    logic            accept, rf_we, wb_valid, ld_go, st_go;
    logic [XLEN-1:0] wb_data;

    cmp_decoder #(.XLEN(XLEN)) u_dec (
        .word_i (fetch_word_i),
        .len_o  (inst_len_o),
        .dec_o  (dec),
        .imm_o  (imm)
    );

    assign accept = fetch_valid_i & ~busy_o;
    assign ld_go  = accept & (dec.kind == OPK_LOAD);
    assign st_go  = accept & (dec.kind == OPK_STORE);

    // Operand select and result mux for register-writing operations
    assign opb = dec.use_rb ? rb_val : imm;
    assign sum = ra_val + opb;
    always_comb begin
        case (dec.kind)
            OPK_MOVI: alu_res = imm;
            OPK_MOV:  alu_res = ra_val;
            default:  alu_res = sum;
        endcase
    end

    assign rf_we    = wb_valid | (accept & dec.wr);
    assign rf_widx  = wb_valid ? wb_idx : dec.rd;
    assign rf_wdata = wb_valid ? wb_data : alu_res;

    cmp_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (rf_we),
        .widx_i   (rf_widx),
        .wdata_i  (rf_wdata),
        .ra_idx_i (dec.ra),
        .rb_idx_i (dec.rb),
        .ra_o     (ra_val),
        .rb_o     (rb_val)
    );

    cmp_lsu #(.XLEN(XLEN), .IDX_W(IDX_W)) u_lsu (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_go_i     (ld_go),
        .st_go_i     (st_go),
        .addr_i      (sum),
        .wdata_i     (rb_val),
        .ld_rd_i     (dec.rd),
        .rsp_valid_i (mem_rsp_valid_i),
        .rsp_data_i  (mem_rsp_data_i),
        .req_valid_o (mem_req_valid_o),
        .req_we_o    (mem_req_we_o),
        .req_addr_o  (mem_req_addr_o),
        .req_wdata_o (mem_req_wdata_o),
        .busy_o      (busy_o),
        .wb_valid_o  (wb_valid),
        .wb_idx_o    (wb_idx),
        .wb_data_o   (wb_data)
    );

    // Completion pulses: one per accepted instruction, load on response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_adv_o      <= 1'b0;
            jump_valid_o  <= 1'b0;
            jump_target_o <= '0;
            illegal_o     <= 1'b0;
            unsupported_o <= 1'b0;
        end else begin
            pc_adv_o      <= wb_valid | (accept & (dec.wr | st_go | (dec.kind == OPK_NOP)));
            jump_valid_o  <= accept & (dec.kind == OPK_RET);
            illegal_o     <= accept & (dec.kind == OPK_ILL);
            unsupported_o <= accept & (dec.kind == OPK_UNSUP);
            if (accept && dec.kind == OPK_RET)
                jump_target_o <= ra_val;
        end
    end

    // R14
    one_completion_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pc_adv_o, jump_valid_o, illegal_o, unsupported_o}));
    // R8
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec.kind == OPK_RET) |=> (jump_valid_o && jump_target_o == $past(ra_val)));
    // R10
    no_mem_on_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_o || unsupported_o) |-> !mem_req_valid_o);
    // R12
    no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !jump_valid_o && !illegal_o && !unsupported_o);
endmodule

// File: tb/cmp_exec_unit_test.sv
`timescale 1ns/1ps
module cmp_exec_unit_test;
    localparam int EV_REQ = 0, EV_ADV = 1, EV_JMP = 2, EV_ILL = 3, EV_UNS = 4;

    typedef struct {
        int          kind;
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
        string       req;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [23:0] fetch_word = '0;
    logic [1:0]  inst_len;
    logic        busy, mreq_v, mreq_we, pc_adv, jv, ill, uns;
    logic [31:0] mreq_a, mreq_d, jtgt;
    logic        rsp_v = 1'b0;
    logic [31:0] rsp_d = '0;

    int n_chk = 0, n_bad = 0, cycles = 0;
    ev_t exp_q[$];
    logic [31:0] m [16];

    always #2 clk = ~clk;

    cmp_exec_unit #(.XLEN(32)) uut (
        .clk(clk), .rst_n(rst_n), .fetch_valid_i(fetch_valid), .fetch_word_i(fetch_word),
        .inst_len_o(inst_len), .busy_o(busy), .mem_req_valid_o(mreq_v), .mem_req_we_o(mreq_we),
        .mem_req_addr_o(mreq_a), .mem_req_wdata_o(mreq_d), .mem_rsp_valid_i(rsp_v),
        .mem_rsp_data_i(rsp_d), .pc_adv_o(pc_adv), .jump_valid_o(jv), .jump_target_o(jtgt),
        .illegal_o(ill), .unsupported_o(uns)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    function automatic logic [23:0] enc(input int op, input int t, input int s, input int r);
        return {8'h00, 4'(r), 4'(s), 4'(t), 4'(op)};
    endfunction

    task automatic push(input int k, input logic we, input logic [31:0] a, input logic [31:0] d, input string req);
        ev_t e;
        e.kind = k; e.we = we; e.addr = a; e.data = d; e.req = req;
        exp_q.push_back(e);
    endtask

    // Monitor: pop expected items as the design produces results
    task automatic take(input int k, input logic we, input logic [31:0] a, input logic [31:0] d);
        ev_t e;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R14 unexpected event", 32'(k), 32'hffffffff);
        end else begin
            e = exp_q.pop_front();
            chk(e.kind == k, e.req, 32'(k), 32'(e.kind));
            if (e.kind == k && k == EV_REQ) begin
                chk(e.we == we, e.req, 32'(we), 32'(e.we));
                chk(e.addr == a, e.req, a, e.addr);
                chk(e.data == d, e.req, d, e.data);
            end
            if (e.kind == k && k == EV_JMP) chk(e.addr == a, e.req, a, e.addr);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (mreq_v) take(EV_REQ, mreq_we, mreq_a, mreq_d);
            if (pc_adv) take(EV_ADV, 1'b0, 32'h0, 32'h0);
            if (jv)     take(EV_JMP, 1'b0, jtgt, 32'h0);
            if (ill)    take(EV_ILL, 1'b0, 32'h0, 32'h0);
            if (uns)    take(EV_UNS, 1'b0, 32'h0, 32'h0);
        end
    end

    // Drive one instruction for one cycle and check its reported length (R1)
    task automatic drive(input logic [23:0] w);
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_word = w;
        #1;
        chk(inst_len == (w[3] ? 2'd2 : 2'd3), "R1", 32'(inst_len), w[3] ? 32'd2 : 32'd3);
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    // Driver for every non-load instruction: model the result, push events
    task automatic issue(input logic [23:0] w);
        logic [3:0] op, t, s, r;
        logic [31:0] v;
        op = w[3:0]; t = w[7:4]; s = w[11:8]; r = w[15:12];
        if (op < 8) push(EV_UNS, 0, 0, 0, "R10 full-length");
        else case (op)
            9: begin
                push(EV_REQ, 1, m[s] + 32'(r) * 4, m[t], "R3 store");
                push(EV_ADV, 0, 0, 0, "R3 store adv");
            end
            10: begin m[r] = m[s] + m[t]; push(EV_ADV, 0, 0, 0, "R4"); end
            11: begin m[r] = m[s] + ((t == 0) ? 32'hffffffff : 32'(t)); push(EV_ADV, 0, 0, 0, "R5"); end
            12: if (t < 8) begin
                    v = {25'd0, t[2:0], r};
                    if (t[2:1] == 2'b11) v[31:7] = '1;
                    m[s] = v;
                    push(EV_ADV, 0, 0, 0, "R6");
                end else push(EV_UNS, 0, 0, 0, "R10 branch");
            13: if (r == 0) begin m[t] = m[s]; push(EV_ADV, 0, 0, 0, "R7"); end
                else if (r == 15) begin
                    if (t == 0) push(EV_JMP, 0, m[0], 0, "R8");
                    else if (t == 3) push(EV_ADV, 0, 0, 0, "R9");
                    else if (t == 1 || t == 2) push(EV_UNS, 0, 0, 0, "R10 sub-op");
                    else push(EV_ILL, 0, 0, 0, "R11 sub-op");
                end else push(EV_ILL, 0, 0, 0, "R11 r field");
            default: push(EV_ILL, 0, 0, 0, "R11 opcode");
        endcase
        drive(w);
    endtask

    // Load with a held-off competing instruction during the wait (R2, R12)
    task automatic do_load(input int t, input int s, input int r, input logic [31:0] data, input logic [23:0] stray);
        push(EV_REQ, 0, m[s] + 32'(r) * 4, 0, "R2 load req");
        push(EV_ADV, 0, 0, 0, "R2 load adv");
        drive(enc(8, t, s, r));
        chk(busy == 1'b1, "R2 busy after issue", 32'(busy), 1);
        fetch_valid = 1'b1;
        fetch_word = stray;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(busy == 1'b1, "R12 busy held", 32'(busy), 1);
        end
        fetch_valid = 1'b0;
        rsp_v = 1'b1;
        rsp_d = data;
        @(negedge clk);
        rsp_v = 1'b0;
        chk(busy == 1'b0, "R2 busy cleared", 32'(busy), 0);
        m[t] = data;
    endtask

    // Read a register back at the memory port through a store at R0+4*r
    task automatic readback(input int t, input int r);
        issue(enc(9, t, 0, r));
    endtask

    initial begin
        for (int i = 0; i < 16; i++) m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13
        chk({mreq_v, pc_adv, jv, ill, uns, busy} == 6'b0, "R13 outputs", 32'({mreq_v, pc_adv, jv, ill, uns, busy}), 0);
        readback(3, 1);
        readback(15, 2);
        // R6: 95, -32, 0x37, -1
        issue(enc(12, 5, 1, 15));
        issue(enc(12, 6, 2, 0));
        issue(enc(12, 3, 3, 7));
        issue(enc(12, 7, 4, 15));
        for (int i = 1; i < 5; i++) readback(i, i);
        // R4, R5
        issue(enc(10, 2, 1, 5));
        issue(enc(11, 0, 3, 6));
        issue(enc(11, 9, 1, 7));
        issue(enc(11, 15, 2, 11));
        // R7
        issue(enc(13, 8, 4, 0));
        for (int i = 5; i < 12; i++) readback(i, i);
        // R2 with a blocked add into R10 (R12)
        do_load(9, 1, 2, 32'hdeadbeef, enc(10, 1, 1, 10));
        readback(9, 0);
        readback(10, 3);
        // R12: stray response while idle
        @(negedge clk);
        rsp_v = 1'b1;
        rsp_d = 32'h12345678;
        @(negedge clk);
        rsp_v = 1'b0;
        chk(busy == 1'b0, "R12 stray response", 32'(busy), 0);
        // R8, R9
        issue(enc(12, 4, 0, 0));
        issue(enc(13, 0, 0, 15));
        issue(enc(13, 3, 0, 15));
        // R10, R11: flags with no state change
        issue(24'h123405);
        issue(24'hABCDE0);
        issue(enc(12, 8, 5, 3));
        issue(enc(13, 1, 0, 15));
        issue(enc(13, 2, 0, 15));
        issue(enc(13, 6, 0, 15));
        issue(enc(13, 9, 0, 15));
        issue(enc(13, 2, 3, 4));
        issue(enc(14, 1, 2, 3));
        issue(enc(15, 1, 2, 3));
        for (int i = 0; i < 12; i++) readback(i, i);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R14 pending events", 32'(exp_q.size()), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule